// File: doc/BRIEF.md
# Alarm Indicator Output Controller

This block turns two internal alarm conditions, an over-temperature condition and a general alert condition, into signals on two active-low pins. A 2-bit mode field per pin picks the signalling style: a steady level, a pin-specific alternative (a one-shot low pulse for the over-temperature pin, an active-high level for the alert pin), a 1 Hz blink, or a beep tone that alternates between 400 Hz and 800 Hz. A shared beeper output carries the tone whenever any source asks for it.

A case-intrusion input sets a sticky status bit. Software clears it by writing 1, but only once the intrusion input has gone away. Two enable bits route a latched intrusion to the beeper and to a wake/event request output. Software reaches one control register and one status register over a simple register bus. A slow timebase tick sets the pulse and blink timing, and the tone frequencies come from a prescaler that runs at the system clock rate.

Top module: `alarm_indicator_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00, both pins are high, and beepOut and eventReq are low.
- R2: With the over-temperature mode (control bits [5:4]) at 00, ovtN is low exactly while ovtCond is high.
- R3: With the over-temperature mode at 01, a rising edge of ovtCond drives ovtN low for PULSE_TICKS timebase ticks. ovtN then returns high even if ovtCond stays high.
- R4: With the alert mode (control bits [1:0]) at 00, alertN is low while alertCond is high. With the mode at 01, alertN equals alertCond (active high).
- R5: In mode 10, a pin goes low when its condition rises. It stays low for HALF_SEC_TICKS ticks, then is high for HALF_SEC_TICKS ticks, and repeats while the condition holds. It goes high as soon as the condition clears.
- R6: In mode 11, a pin with its condition high carries a square wave whose half-period alternates between TONE_LO_HALF and TONE_HI_HALF clocks, switching every QUARTER_TICKS ticks. beepOut carries the same wave. With the condition low, the pin stays high and that pin adds nothing to beepOut.
- R7: caseIn high sets the intrusion status (status register bit 0, address 1) on the next clock.
- R8: Writing 1 to status bit 0 clears it only while caseIn is low. Writing 0 leaves it unchanged. A status write does not change the control register.
- R9: With the intrusion beep enable (control bit 6) at 1 and the status set, beepOut carries the tone. With the enable at 0, the intrusion does not reach beepOut.
- R10: eventReq is high exactly while the intrusion event enable (control bit 2) is 1 and the status is set.
- R11: Control bits 7 and 3 read back as written and have no effect on any output. The control register sits at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timebase strobe, one clock wide |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = control, 1 = status |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| ovtCond | input | 1 | Over-temperature condition |
| alertCond | input | 1 | Alert condition |
| caseIn | input | 1 | Case intrusion detected |
| ovtN | output | 1 | Over-temperature pin, active low |
| alertN | output | 1 | Alert pin |
| beepOut | output | 1 | Shared beeper tone |
| eventReq | output | 1 | Wake/event request |

## Verification
The bench attacks the write-1-to-clear while the intrusion input is still high. A design that lets the clear win would drop the status and lose an event that is still active. It checks that the pulse mode fires only once per rising edge, because a design keyed on level would hold the pin low or fire again. It measures the tone run lengths to see both half-periods: a design that never switches tone, or uses one divider for both, shows only one length. It also sets the reserved bits and clears the routing enables to show that a miswired enable or a decoded reserved bit changes the pins or the beeper.

// File: rtl/alarm_ind_pkg.sv
package alarm_ind_pkg;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ALT   = 2'b01,
    MODE_BLINK = 2'b10,
    MODE_BEEP  = 2'b11
  } pin_mode_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic      rsvHi;
    logic      caseBeepEn;
    pin_mode_e ovtMode;
    logic      rsvLo;
    logic      caseEvtEn;
    pin_mode_e alertMode;
  } ctrl_reg_t;

  localparam int NUM_CH   = 2;
  localparam int CH_ALERT = 0;
  localparam int CH_OVT   = 1;

  typedef struct packed {
    logic              tickEn;
    logic [NUM_CH-1:0] condRise;
  } strobe_t;

endpackage

// File: rtl/alarm_ind_ctrl.sv
module alarm_ind_ctrl
  import alarm_ind_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [NUM_CH-1:0] cond,
  input  logic              caseIn,
  output ctrl_reg_t         cfg,
  output logic              caseSts,
  output logic              eventReq,
  output strobe_t           strb
);
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STS  = 1'b1;

  logic [NUM_CH-1:0] condPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      caseSts  <= 1'b0;
      condPrev <= '0;
    end else begin
      condPrev <= cond;
      if (regWrEn && regAddr == ADDR_CTRL) cfg <= ctrl_reg_t'(regWrData);
      if (caseIn) caseSts <= 1'b1;
      else if (regWrEn && regAddr == ADDR_STS && regWrData[0]) caseSts <= 1'b0;
    end
  end

  assign strb.tickEn   = tick;
  assign strb.condRise = cond & ~condPrev;
  assign eventReq      = cfg.caseEvtEn & caseSts;
  assign regRdData     = (regAddr == ADDR_STS) ? {7'b0, caseSts} : 8'(cfg);

endmodule

// File: rtl/alarm_ind_datapath.sv
module alarm_ind_datapath
  import alarm_ind_pkg::*;
#(
  parameter int HALF_SEC_TICKS = 500,
  parameter int QUARTER_TICKS  = 250,
  parameter int PULSE_TICKS    = 4,
  parameter int TONE_LO_HALF   = 312500,
  parameter int TONE_HI_HALF   = 156250
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_reg_t         cfg,
  input  logic [NUM_CH-1:0] cond,
  input  logic              caseSts,
  input  strobe_t           strb,
  output logic              ovtN,
  output logic              alertN,
  output logic              beepOut
);
  localparam int HALF_W  = $clog2(HALF_SEC_TICKS + 1);
  localparam int QTR_W   = $clog2(QUARTER_TICKS + 1);
  localparam int PULSE_W = $clog2(PULSE_TICKS + 1);
  localparam int TONE_W  = $clog2(TONE_LO_HALF + 1);

  // tone generator: free running, frequency alternates each quarter window
  logic [QTR_W-1:0]  qtrCnt;
  logic              toneHi;
  logic [TONE_W-1:0] toneCnt;
  logic              toneWave;
  logic [TONE_W-1:0] curHalf;

  assign curHalf = toneHi ? TONE_W'(TONE_HI_HALF - 1) : TONE_W'(TONE_LO_HALF - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qtrCnt   <= '0;
      toneHi   <= 1'b0;
      toneCnt  <= '0;
      toneWave <= 1'b0;
    end else begin
      if (strb.tickEn) begin
        if (qtrCnt == QTR_W'(QUARTER_TICKS - 1)) begin
          qtrCnt <= '0;
          toneHi <= ~toneHi;
        end else begin
          qtrCnt <= qtrCnt + 1'b1;
        end
      end
      if (toneCnt >= curHalf) begin
        toneCnt  <= '0;
        toneWave <= ~toneWave;
      end else begin
        toneCnt <= toneCnt + 1'b1;
      end
    end
  end

  pin_mode_e         chMode [NUM_CH];
  logic [NUM_CH-1:0] pinN;
  logic [NUM_CH-1:0] beepReq;

  assign chMode[CH_ALERT] = cfg.alertMode;
  assign chMode[CH_OVT]   = cfg.ovtMode;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [HALF_W-1:0] blinkCnt;
    logic              blinkPhase;
    logic              altPin;
    logic              pinLocal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blinkCnt   <= '0;
        blinkPhase <= 1'b0;
      end else if (!cond[ch] || strb.condRise[ch]) begin
        blinkCnt   <= '0;
        blinkPhase <= 1'b0;
      end else if (strb.tickEn) begin
        if (blinkCnt == HALF_W'(HALF_SEC_TICKS - 1)) begin
          blinkCnt   <= '0;
          blinkPhase <= ~blinkPhase;
        end else begin
          blinkCnt <= blinkCnt + 1'b1;
        end
      end
    end

    if (ch == CH_OVT) begin : g_pulse
      logic [PULSE_W-1:0] pulseCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                 pulseCnt <= '0;
        else if (strb.condRise[ch])                pulseCnt <= PULSE_W'(PULSE_TICKS);
        else if (strb.tickEn && pulseCnt != '0)    pulseCnt <= pulseCnt - 1'b1;
      end
      assign altPin = (pulseCnt == '0);
    end else begin : g_high
      assign altPin = cond[ch];
    end

    always_comb begin
      case (chMode[ch])
        MODE_LEVEL: pinLocal = ~cond[ch];
        MODE_ALT:   pinLocal = altPin;
        MODE_BLINK: pinLocal = ~(cond[ch] & ~blinkPhase);
        default:    pinLocal = ~(cond[ch] & toneWave);
      endcase
    end

    assign pinN[ch]    = pinLocal;
    assign beepReq[ch] = cond[ch] && (chMode[ch] == MODE_BEEP);
  end

  assign ovtN    = pinN[CH_OVT];
  assign alertN  = pinN[CH_ALERT];
  assign beepOut = toneWave & ((|beepReq) | (cfg.caseBeepEn & caseSts));

endmodule

// File: rtl/alarm_indicator_ctrl.sv
module alarm_indicator_ctrl
  import alarm_ind_pkg::*;
#(
  parameter int HALF_SEC_TICKS = 500,
  parameter int QUARTER_TICKS  = 250,
  parameter int PULSE_TICKS    = 4,
  parameter int TONE_LO_HALF   = 312500,
  parameter int TONE_HI_HALF   = 156250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       regWrEn,
  input  logic       regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       ovtCond,
  input  logic       alertCond,
  input  logic       caseIn,
  output logic       ovtN,
  output logic       alertN,
  output logic       beepOut,
  output logic       eventReq
);
  ctrl_reg_t         cfg;
  strobe_t           strb;
  logic              caseSts;
  logic [NUM_CH-1:0] cond;

  assign cond[CH_ALERT] = alertCond;
  assign cond[CH_OVT]   = ovtCond;

  alarm_ind_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cond(cond), .caseIn(caseIn),
    .cfg(cfg), .caseSts(caseSts), .eventReq(eventReq), .strb(strb)
  );

  alarm_ind_datapath #(
    .HALF_SEC_TICKS(HALF_SEC_TICKS), .QUARTER_TICKS(QUARTER_TICKS),
    .PULSE_TICKS(PULSE_TICKS), .TONE_LO_HALF(TONE_LO_HALF), .TONE_HI_HALF(TONE_HI_HALF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cond(cond), .caseSts(caseSts), .strb(strb),
    .ovtN(ovtN), .alertN(alertN), .beepOut(beepOut)
  );

endmodule

// File: rtl/alarm_indicator_chk.sv
module alarm_indicator_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] ovtMode,
  input logic [1:0] alertMode,
  input logic       ovtCond,
  input logic       alertCond,
  input logic       caseIn,
  input logic       caseSts,
  input logic       ovtN,
  input logic       alertN,
  input logic       beepOut,
  input logic       eventReq
);
  AST_OVT_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (ovtMode == 2'b00) |-> (ovtN == !ovtCond)); // R2
  AST_ALERT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (alertMode == 2'b01) |-> (alertN == alertCond)); // R4
  AST_BEEP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ovtCond && !alertCond && !caseSts) |-> !beepOut); // R6
  AST_STS_SET: assert property (@(posedge clk) disable iff (!rstN)
    caseIn |=> caseSts); // R7
  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (caseSts && caseIn) |=> caseSts); // R8
  AST_EVT_NEEDS_STS: assert property (@(posedge clk) disable iff (!rstN)
    !caseSts |-> !eventReq); // R10
endmodule

bind alarm_indicator_ctrl alarm_indicator_chk u_chk (
  .clk(clk), .rstN(rstN),
  .ovtMode(cfg.ovtMode), .alertMode(cfg.alertMode),
  .ovtCond(ovtCond), .alertCond(alertCond), .caseIn(caseIn), .caseSts(caseSts),
  .ovtN(ovtN), .alertN(alertN), .beepOut(beepOut), .eventReq(eventReq)
);

// File: tb/alarm_indicator_ctrl_tb.sv
module alarm_indicator_ctrl_tb;
  localparam int HALF = 4;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoTick = 1'b0, autoPulse = 1'b0, manTick = 1'b0;
  logic tick;
  logic regWrEn = 1'b0, regAddr = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic ovtCond = 1'b0, alertCond = 1'b0, caseIn = 1'b0;
  logic ovtN, alertN, beepOut, eventReq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign tick = autoPulse | manTick;

  alarm_indicator_ctrl #(
    .HALF_SEC_TICKS(HALF), .QUARTER_TICKS(2), .PULSE_TICKS(PULSE),
    .TONE_LO_HALF(6), .TONE_HI_HALF(3)
  ) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ovtCond(ovtCond), .alertCond(alertCond),
    .caseIn(caseIn), .ovtN(ovtN), .alertN(alertN), .beepOut(beepOut), .eventReq(eventReq)
  );

  // periodic tick every 20 clocks when enabled
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      autoPulse = autoTick && (cnt % 20 == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic oneTick();
    manTick = 1'b1; step(); manTick = 1'b0;
  endtask

  // level-mode table: ctrl, ovtCond, alertCond, expOvtN, expAlertN
  localparam logic [11:0] VEC [8] = '{
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h01, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h88, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h89, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    logic [7:0] rd;
    int run, run3, run6, mism, ones, zeros;
    logic prev;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    rdReg(1'b0, rd); check(rd == 8'h00, "R1 ctrl", rd, 0);
    rdReg(1'b1, rd); check(rd == 8'h00, "R1 status", rd, 0);
    check({ovtN, alertN, beepOut, eventReq} == 4'b1100, "R1 outputs",
          {ovtN, alertN, beepOut, eventReq}, 4'b1100);

    // table walk: R2 R4 R11
    foreach (VEC[i]) begin
      wrReg(1'b0, VEC[i][11:4]);
      ovtCond = VEC[i][3]; alertCond = VEC[i][2];
      step();
      check({ovtN, alertN} == VEC[i][1:0], "R2/R4/R11 pins", {ovtN, alertN}, VEC[i][1:0]);
      rdReg(1'b0, rd); check(rd == VEC[i][11:4], "R11 readback", rd, VEC[i][11:4]);
    end
    ovtCond = 0; alertCond = 0;
    wrReg(1'b0, 8'h00);

    // R3 pulse mode
    wrReg(1'b0, 8'h10);
    ovtCond = 1'b1; step();
    check(ovtN == 1'b0, "R3 pulse start", ovtN, 0);
    repeat (PULSE - 1) oneTick();
    check(ovtN == 1'b0, "R3 pulse held", ovtN, 0);
    oneTick();
    check(ovtN == 1'b1, "R3 pulse end", ovtN, 1);
    repeat (3) oneTick();
    check(ovtN == 1'b1, "R3 no refire", ovtN, 1);
    ovtCond = 1'b0; step(); step();
    ovtCond = 1'b1; step();
    check(ovtN == 1'b0, "R3 second edge", ovtN, 0);
    ovtCond = 1'b0; repeat (PULSE) oneTick();

    // R5 blink on alert pin
    wrReg(1'b0, 8'h02);
    alertCond = 1'b1; step();
    check(alertN == 1'b0, "R5 blink start low", alertN, 0);
    repeat (HALF - 1) oneTick();
    check(alertN == 1'b0, "R5 low phase", alertN, 0);
    oneTick();
    check(alertN == 1'b1, "R5 high phase", alertN, 1);
    repeat (HALF) oneTick();
    check(alertN == 1'b0, "R5 low again", alertN, 0);
    alertCond = 1'b0; step();
    check(alertN == 1'b1, "R5 clears", alertN, 1);

    // R6 beep mode on ovt pin
    autoTick = 1'b1;
    wrReg(1'b0, 8'h30);
    ovtCond = 1'b1; step();
    run = 0; run3 = 0; run6 = 0; mism = 0; prev = ovtN;
    for (int c = 0; c < 400; c++) begin
      if (beepOut != !ovtN) mism++;
      if (ovtN == prev) run++;
      else begin
        if (run == 3) run3++;
        if (run == 6) run6++;
        run = 1; prev = ovtN;
      end
      step();
    end
    check(run3 > 0, "R6 high tone seen", run3, 1);
    check(run6 > 0, "R6 low tone seen", run6, 1);
    check(mism == 0, "R6 beepOut follows pin", mism, 0);
    ovtCond = 1'b0; step();
    ones = 0; zeros = 0;
    for (int c = 0; c < 100; c++) begin
      if (beepOut) ones++;
      if (!ovtN) zeros++;
      step();
    end
    check(ones == 0 && zeros == 0, "R6 idle without condition", ones + zeros, 0);

    // R7 status set
    wrReg(1'b0, 8'h00);
    caseIn = 1'b1; step();
    rdReg(1'b1, rd); check(rd == 8'h01, "R7 status set", rd, 1);

    // R8 clear blocked while caseIn high
    wrReg(1'b1, 8'h01);
    rdReg(1'b1, rd); check(rd == 8'h01, "R8 clear blocked", rd, 1);
    caseIn = 1'b0; step();
    wrReg(1'b1, 8'h00);
    rdReg(1'b1, rd); check(rd == 8'h01, "R8 write 0 ignored", rd, 1);

    // R9 beep routing
    wrReg(1'b0, 8'h40);
    ones = 0; zeros = 0;
    for (int c = 0; c < 100; c++) begin
      if (beepOut) ones++; else zeros++;
      step();
    end
    check(ones > 0 && zeros > 0, "R9 intrusion beeps", ones, 1);
    wrReg(1'b0, 8'h88);
    ones = 0;
    for (int c = 0; c < 100; c++) begin
      if (beepOut) ones++;
      step();
    end
    check(ones == 0, "R9/R11 beep disabled", ones, 0);

    // R10 event routing
    wrReg(1'b0, 8'h04);
    check(eventReq == 1'b1, "R10 event on", eventReq, 1);
    wrReg(1'b0, 8'h00);
    check(eventReq == 1'b0, "R10 event off", eventReq, 0);

    // R8 clear accepted, control untouched
    wrReg(1'b0, 8'h04);
    wrReg(1'b1, 8'hFF);
    rdReg(1'b1, rd); check(rd == 8'h00, "R8 clear", rd, 0);
    rdReg(1'b0, rd); check(rd == 8'h04, "R8 ctrl untouched", rd, 4);
    check(eventReq == 1'b0, "R10 event drops with status", eventReq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule